// File: doc/BRIEF.md
# Device Resource Allocation Registry

This block keeps a table of the devices attached to a system. Each device describes itself on a registration stream with four values: a base address for its register window, the window size, a first interrupt line, and the number of interrupt lines it uses. A base of zero asks the block to pick an address. A first line of zero, when the device uses at least one line, asks the block to pick the lines. Addresses and lines are handed out from two running counters. Each counter moves forward only by what it hands out. The completed descriptor is appended to a fixed-depth table in the order the registrations arrive. An enumerator downstream reads the table by slot index.

The same block also drives the interrupt lines. A device names one of its own lines by local index and gives a level. The block adds the device's first line to that index and drives the resulting bit of a global interrupt vector. If the local index is out of range, no bit changes and an error pulse is raised instead.

Stream rules for registration: a request is accepted in any cycle where `req_valid` and `req_ready` are both high. `req_ready` is low only while `init_valid` is high. The response has no back-pressure. It is presented combinationally in the acceptance cycle, and the table entry commits at the clock edge that ends that cycle.

Top module: `dev_alloc_registry`

## Requirements
- R1: After reset the table holds no entries, `tbl_count` is 0, `tbl_full` is 0, `irq_vec` is all zero, `irq_err` is 0, and both allocation counters are zero.
- R2: A cycle with `init_valid` high loads the free-address counter from `init_base` and the free-line counter from `init_irq`. In that cycle `req_ready` is low, so no request is accepted. The table contents and `tbl_count` are not changed by initialisation.
- R3: An accepted, non-rejected request with `req_base` equal to 0 receives the current free-address value on `rsp_base`. The free-address counter then advances by `req_size`.
- R4: An accepted request with a nonzero `req_base` returns that same value on `rsp_base` and leaves the free-address counter unchanged.
- R5: The first line is allocated only when `req_irq` is 0 and `req_irq_cnt` is greater than 0. In that case `rsp_irq` gets the free-line value and the free-line counter advances by `req_irq_cnt`. In every other case `rsp_irq` equals `req_irq` and the free-line counter is unchanged.
- R6: Each committed descriptor goes into slot `tbl_count`, after which `tbl_count` increments. Reading with `rd_idx` below `tbl_count` returns that slot's base, size, first line and line count with `rd_hit` high. For `rd_idx` at or above `tbl_count`, `rd_hit` is low.
- R7: When `tbl_full` is high (count equals DEPTH), an accepted request is rejected. `rsp_full` is 1, `rsp_base`, `rsp_irq` and `rsp_slot` are 0, and neither the table nor either counter changes.
- R8: A cycle with `irq_set_valid` high and a legal index sets bit (first line of device `irq_dev` + `irq_local`) of `irq_vec` to `irq_level`, visible after the next clock edge. All other bits are unchanged.
- R9: An interrupt drive is illegal when `irq_dev` is not a filled slot, when `irq_local` is at or above that device's line count, or when the computed line is at or above NIRQ. An illegal drive leaves `irq_vec` unchanged and makes `irq_err` high for exactly the cycle after it.
- R10: `rsp_valid` is high in exactly the cycles in which a request is accepted. `rsp_slot` then gives the slot that was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_valid | input | 1 | Load both allocation counters |
| init_base | input | AW | Starting free address |
| init_irq | input | IW | Starting free interrupt line |
| req_valid | input | 1 | Registration request valid |
| req_ready | output | 1 | Registration request ready |
| req_base | input | AW | Requested base, 0 = allocate |
| req_size | input | AW | Window size in bytes |
| req_irq | input | IW | Requested first line, 0 = allocate |
| req_irq_cnt | input | CW | Number of interrupt lines |
| rsp_valid | output | 1 | Response valid (acceptance cycle) |
| rsp_full | output | 1 | Request rejected, table full |
| rsp_base | output | AW | Base assigned to the device |
| rsp_irq | output | IW | First line assigned to the device |
| rsp_slot | output | $clog2(DEPTH) | Slot written |
| tbl_count | output | $clog2(DEPTH+1) | Number of filled slots |
| tbl_full | output | 1 | Table at full depth |
| rd_idx | input | $clog2(DEPTH) | Enumeration read slot |
| rd_hit | output | 1 | Read slot is filled |
| rd_base | output | AW | Slot base |
| rd_size | output | AW | Slot window size |
| rd_irq | output | IW | Slot first line |
| rd_irq_cnt | output | CW | Slot line count |
| irq_set_valid | input | 1 | Drive one device interrupt |
| irq_dev | input | $clog2(DEPTH) | Slot of the device driving |
| irq_local | input | CW | Device-local line index |
| irq_level | input | 1 | Level to drive |
| irq_vec | output | NIRQ | Global interrupt lines |
| irq_err | output | 1 | Illegal drive pulse |

## Verification
Registrations mix a zero base with a fixed base, and a zero first line with a fixed one, including a device that uses no lines. This separates the four allocation paths: a wrong condition shows up as a counter that moves when it should not, or one that stays put when it should move. Interrupt drives cover a legal set and a legal clear, an index one past the count, a device that uses no lines, an empty slot, and a line that lands past the vector. The table is then filled to depth and driven once more to expose the rejection path. A re-initialisation in the middle of the run shows that the counters reload while the table entries stay.

// File: rtl/dev_alloc_pkg.sv
package dev_alloc_pkg;
  localparam int DEF_DEPTH = 8;
  localparam int DEF_AW    = 32;
  localparam int DEF_IW    = 8;
  localparam int DEF_CW    = 4;
  localparam int DEF_NIRQ  = 32;

  typedef enum logic [1:0] {
    IRQ_OK       = 2'd0,
    IRQ_BAD_DEV  = 2'd1,
    IRQ_BAD_IDX  = 2'd2,
    IRQ_BAD_LINE = 2'd3
  } irq_chk_e;
endpackage

// File: rtl/dev_alloc_unit.sv
module dev_alloc_unit #(
  parameter int AW = 32,
  parameter int IW = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_valid,
  input  logic [AW-1:0] init_base,
  input  logic [IW-1:0] init_irq,
  input  logic          commit,
  input  logic [AW-1:0] req_base,
  input  logic [AW-1:0] req_size,
  input  logic [IW-1:0] req_irq,
  input  logic [CW-1:0] req_cnt,
  output logic [AW-1:0] asg_base,
  output logic [IW-1:0] asg_irq,
  output logic [AW-1:0] free_base,
  output logic [IW-1:0] free_irq
);
  logic take_base, take_irq;

  always_comb begin
    take_base = (req_base == '0);
    take_irq  = (req_irq == '0) && (req_cnt != '0);
    asg_base  = take_base ? free_base : req_base;
    asg_irq   = take_irq  ? free_irq  : req_irq;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_base <= '0;
      free_irq  <= '0;
    end else if (init_valid) begin
      free_base <= init_base;
      free_irq  <= init_irq;
    end else if (commit) begin
      if (take_base) free_base <= free_base + req_size;
      if (take_irq)  free_irq  <= free_irq + IW'(req_cnt);
    end
  end
endmodule

// File: rtl/dev_desc_table.sv
module dev_desc_table #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int IW    = 8,
  parameter int CW    = 4,
  localparam int IDXW = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_base,
  input  logic [AW-1:0]   wr_size,
  input  logic [IW-1:0]   wr_irq,
  input  logic [CW-1:0]   wr_cnt,
  input  logic [IDXW-1:0] rd_idx,
  output logic            rd_hit,
  output logic [AW-1:0]   rd_base,
  output logic [AW-1:0]   rd_size,
  output logic [IW-1:0]   rd_irq,
  output logic [CW-1:0]   rd_cnt,
  input  logic [IDXW-1:0] lk_idx,
  output logic            lk_hit,
  output logic [IW-1:0]   lk_irq,
  output logic [CW-1:0]   lk_cnt,
  output logic [CNTW-1:0] count,
  output logic            full
);
  logic [AW-1:0] base_q [DEPTH];
  logic [AW-1:0] size_q [DEPTH];
  logic [IW-1:0] irq_q  [DEPTH];
  logic [CW-1:0] cnt_q  [DEPTH];

  assign full = (count == CNTW'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n)                count <= '0;
    else if (wr_en && !full)   count <= count + 1'b1;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[g] <= '0;
        size_q[g] <= '0;
        irq_q[g]  <= '0;
        cnt_q[g]  <= '0;
      end else if (wr_en && (count == CNTW'(g))) begin
        base_q[g] <= wr_base;
        size_q[g] <= wr_size;
        irq_q[g]  <= wr_irq;
        cnt_q[g]  <= wr_cnt;
      end
    end
  end

  always_comb begin
    rd_hit  = (CNTW'(rd_idx) < count);
    rd_base = base_q[rd_idx];
    rd_size = size_q[rd_idx];
    rd_irq  = irq_q[rd_idx];
    rd_cnt  = cnt_q[rd_idx];
    lk_hit  = (CNTW'(lk_idx) < count);
    lk_irq  = irq_q[lk_idx];
    lk_cnt  = cnt_q[lk_idx];
  end
endmodule

// File: rtl/dev_irq_router.sv
module dev_irq_router
  import dev_alloc_pkg::*;
#(
  parameter int NIRQ = 32,
  parameter int IW   = 8,
  parameter int CW   = 4,
  localparam int LW  = ((IW > CW) ? IW : CW) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_valid,
  input  logic            level,
  input  logic [CW-1:0]   local_idx,
  input  logic            dev_hit,
  input  logic [IW-1:0]   dev_first,
  input  logic [CW-1:0]   dev_cnt,
  output logic [NIRQ-1:0] irq_vec,
  output logic            irq_err
);
  logic [LW-1:0] line;
  irq_chk_e      cause;

  always_comb begin
    line = LW'(dev_first) + LW'(local_idx);
    if (!dev_hit)                    cause = IRQ_BAD_DEV;
    else if (local_idx >= dev_cnt)   cause = IRQ_BAD_IDX;
    else if (line >= LW'(NIRQ))      cause = IRQ_BAD_LINE;
    else                             cause = IRQ_OK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_err <= 1'b0;
    else        irq_err <= set_valid && (cause != IRQ_OK);
  end

  for (genvar g = 0; g < NIRQ; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n)
        irq_vec[g] <= 1'b0;
      else if (set_valid && (cause == IRQ_OK) && (line == LW'(g)))
        irq_vec[g] <= level;
    end
  end
endmodule

// File: rtl/dev_alloc_registry.sv
module dev_alloc_registry
  import dev_alloc_pkg::*;
#(
  parameter int DEPTH = DEF_DEPTH,
  parameter int AW    = DEF_AW,
  parameter int IW    = DEF_IW,
  parameter int CW    = DEF_CW,
  parameter int NIRQ  = DEF_NIRQ,
  localparam int IDXW = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            init_valid,
  input  logic [AW-1:0]   init_base,
  input  logic [IW-1:0]   init_irq,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [AW-1:0]   req_base,
  input  logic [AW-1:0]   req_size,
  input  logic [IW-1:0]   req_irq,
  input  logic [CW-1:0]   req_irq_cnt,
  output logic            rsp_valid,
  output logic            rsp_full,
  output logic [AW-1:0]   rsp_base,
  output logic [IW-1:0]   rsp_irq,
  output logic [IDXW-1:0] rsp_slot,
  output logic [CNTW-1:0] tbl_count,
  output logic            tbl_full,
  input  logic [IDXW-1:0] rd_idx,
  output logic            rd_hit,
  output logic [AW-1:0]   rd_base,
  output logic [AW-1:0]   rd_size,
  output logic [IW-1:0]   rd_irq,
  output logic [CW-1:0]   rd_irq_cnt,
  input  logic            irq_set_valid,
  input  logic [IDXW-1:0] irq_dev,
  input  logic [CW-1:0]   irq_local,
  input  logic            irq_level,
  output logic [NIRQ-1:0] irq_vec,
  output logic            irq_err
);
  logic          accept, commit;
  logic [AW-1:0] asg_base, free_base;
  logic [IW-1:0] asg_irq, free_irq;
  logic          lk_hit;
  logic [IW-1:0] lk_irq;
  logic [CW-1:0] lk_cnt;

  assign req_ready = !init_valid;
  assign accept    = req_valid && req_ready;
  assign commit    = accept && !tbl_full;

  assign rsp_valid = accept;
  assign rsp_full  = tbl_full;
  assign rsp_base  = tbl_full ? '0 : asg_base;
  assign rsp_irq   = tbl_full ? '0 : asg_irq;
  assign rsp_slot  = tbl_full ? '0 : tbl_count[IDXW-1:0];

  dev_alloc_unit #(.AW(AW), .IW(IW), .CW(CW)) u_alloc (
    .clk(clk), .rst_n(rst_n),
    .init_valid(init_valid), .init_base(init_base), .init_irq(init_irq),
    .commit(commit),
    .req_base(req_base), .req_size(req_size), .req_irq(req_irq), .req_cnt(req_irq_cnt),
    .asg_base(asg_base), .asg_irq(asg_irq),
    .free_base(free_base), .free_irq(free_irq)
  );

  dev_desc_table #(.DEPTH(DEPTH), .AW(AW), .IW(IW), .CW(CW)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(commit), .wr_base(asg_base), .wr_size(req_size),
    .wr_irq(asg_irq), .wr_cnt(req_irq_cnt),
    .rd_idx(rd_idx), .rd_hit(rd_hit), .rd_base(rd_base), .rd_size(rd_size),
    .rd_irq(rd_irq), .rd_cnt(rd_irq_cnt),
    .lk_idx(irq_dev), .lk_hit(lk_hit), .lk_irq(lk_irq), .lk_cnt(lk_cnt),
    .count(tbl_count), .full(tbl_full)
  );

  dev_irq_router #(.NIRQ(NIRQ), .IW(IW), .CW(CW)) u_router (
    .clk(clk), .rst_n(rst_n),
    .set_valid(irq_set_valid), .level(irq_level), .local_idx(irq_local),
    .dev_hit(lk_hit), .dev_first(lk_irq), .dev_cnt(lk_cnt),
    .irq_vec(irq_vec), .irq_err(irq_err)
  );
endmodule

// File: rtl/dev_alloc_checker.sv
module dev_alloc_checker #(
  parameter int AW   = 32,
  parameter int IW   = 8,
  parameter int CW   = 4,
  parameter int NIRQ = 32,
  parameter int CNTW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            init_valid,
  input logic [AW-1:0]   init_base,
  input logic [IW-1:0]   init_irq,
  input logic            accept,
  input logic            commit,
  input logic [AW-1:0]   req_base,
  input logic [AW-1:0]   req_size,
  input logic [AW-1:0]   rsp_base,
  input logic [AW-1:0]   free_base,
  input logic [IW-1:0]   free_irq,
  input logic            tbl_full,
  input logic [CNTW-1:0] tbl_count,
  input logic [NIRQ-1:0] irq_vec,
  input logic            irq_err
);
  assert_init_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    init_valid |=> (free_base == $past(init_base)) && (free_irq == $past(init_irq)));

  assert_base_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && req_base == '0) |=> free_base == $past(free_base) + $past(req_size));

  assert_base_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && req_base != '0) |-> rsp_base == req_base);

  assert_base_still_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && req_base != '0) |=> $stable(free_base));

  assert_append_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> tbl_count == $past(tbl_count) + 1'b1);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && tbl_full) |=> $stable(tbl_count) && $stable(free_base) && $stable(free_irq));

  assert_err_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> $stable(irq_vec));
endmodule

bind dev_alloc_registry dev_alloc_checker #(
  .AW(AW), .IW(IW), .CW(CW), .NIRQ(NIRQ), .CNTW(CNTW)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .init_valid(init_valid), .init_base(init_base), .init_irq(init_irq),
  .accept(accept), .commit(commit),
  .req_base(req_base), .req_size(req_size), .rsp_base(rsp_base),
  .free_base(free_base), .free_irq(free_irq),
  .tbl_full(tbl_full), .tbl_count(tbl_count),
  .irq_vec(irq_vec), .irq_err(irq_err)
);

// File: tb/dev_alloc_registry_test.sv
module dev_alloc_registry_test;
  localparam int DEPTH = 8, AW = 32, IW = 8, CW = 4, NIRQ = 32;
  localparam int IDXW = $clog2(DEPTH), CNTW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic init_valid = 0; logic [AW-1:0] init_base = 0; logic [IW-1:0] init_irq = 0;
  logic req_valid = 0; logic req_ready;
  logic [AW-1:0] req_base = 0, req_size = 0; logic [IW-1:0] req_irq = 0; logic [CW-1:0] req_irq_cnt = 0;
  logic rsp_valid, rsp_full; logic [AW-1:0] rsp_base; logic [IW-1:0] rsp_irq; logic [IDXW-1:0] rsp_slot;
  logic [CNTW-1:0] tbl_count; logic tbl_full;
  logic [IDXW-1:0] rd_idx = 0; logic rd_hit; logic [AW-1:0] rd_base, rd_size;
  logic [IW-1:0] rd_irq; logic [CW-1:0] rd_irq_cnt;
  logic irq_set_valid = 0; logic [IDXW-1:0] irq_dev = 0; logic [CW-1:0] irq_local = 0; logic irq_level = 0;
  logic [NIRQ-1:0] irq_vec; logic irq_err;

  always #5 clk = ~clk;

  dev_alloc_registry uut (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  // model state
  logic [AW-1:0] m_fb = 0; logic [IW-1:0] m_fi = 0; int m_count = 0;
  logic [AW-1:0] m_base [DEPTH]; logic [AW-1:0] m_size [DEPTH];
  logic [IW-1:0] m_irq [DEPTH]; logic [CW-1:0] m_cnt [DEPTH];
  logic [NIRQ-1:0] m_vec = 0;

  // scoreboard queues
  logic [AW-1:0] q_base [$]; logic [IW-1:0] q_irq [$];
  logic q_full [$]; logic [IDXW-1:0] q_slot [$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops an expected response whenever one is presented (R10)
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q_base.size() == 0) chk(0, "R10 unexpected response", 1, 0);
      else begin
        logic [AW-1:0] eb; logic [IW-1:0] ei; logic ef; logic [IDXW-1:0] es;
        eb = q_base.pop_front(); ei = q_irq.pop_front();
        ef = q_full.pop_front(); es = q_slot.pop_front();
        chk(rsp_full == ef, "R7 rsp_full", rsp_full, ef);
        chk(rsp_base == eb, "R3/R4 rsp_base", rsp_base, eb);
        chk(rsp_irq == ei, "R5 rsp_irq", rsp_irq, ei);
        chk(rsp_slot == es, "R10 rsp_slot", rsp_slot, es);
      end
    end
  end

  // driver: called at posedge+1, returns at posedge+1
  task automatic reg_dev(input logic [AW-1:0] b, input logic [AW-1:0] s,
                         input logic [IW-1:0] i, input logic [CW-1:0] c);
    if (m_count == DEPTH) begin
      q_base.push_back('0); q_irq.push_back('0); q_full.push_back(1); q_slot.push_back('0);
    end else begin
      logic [AW-1:0] ab; logic [IW-1:0] ai;
      ab = (b == 0) ? m_fb : b;
      ai = (i == 0 && c != 0) ? m_fi : i;
      if (b == 0) m_fb = m_fb + s;
      if (i == 0 && c != 0) m_fi = m_fi + IW'(c);
      q_base.push_back(ab); q_irq.push_back(ai); q_full.push_back(0); q_slot.push_back(IDXW'(m_count));
      m_base[m_count] = ab; m_size[m_count] = s; m_irq[m_count] = ai; m_cnt[m_count] = c;
      m_count++;
    end
    req_valid = 1; req_base = b; req_size = s; req_irq = i; req_irq_cnt = c;
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic do_init(input logic [AW-1:0] b, input logic [IW-1:0] i);
    init_valid = 1; init_base = b; init_irq = i;
    req_valid = 1; req_base = 0; req_size = 32'h40; req_irq = 0; req_irq_cnt = 1;
    @(negedge clk);
    chk(req_ready == 0, "R2 req_ready low during init", req_ready, 0);
    @(posedge clk); #1;
    init_valid = 0; req_valid = 0;
    m_fb = b; m_fi = i;
  endtask

  task automatic drive_irq(input int dev, input int loc, input logic lvl, input bit bad);
    irq_set_valid = 1; irq_dev = IDXW'(dev); irq_local = CW'(loc); irq_level = lvl;
    if (!bad) m_vec[int'(m_irq[dev]) + loc] = lvl;
    @(posedge clk); #1;
    irq_set_valid = 0;
    @(negedge clk);
    if (bad) chk(irq_err == 1, "R9 irq_err pulse", irq_err, 1);
    else     chk(irq_err == 0, "R8 no error on legal drive", irq_err, 0);
    chk(irq_vec == m_vec, bad ? "R9 irq_vec unchanged" : "R8 irq_vec", irq_vec, m_vec);
    @(posedge clk); #1;
    chk(irq_err == 0, "R9 irq_err one cycle", irq_err, 0);
  endtask

  task automatic check_table();
    for (int k = 0; k < DEPTH; k++) begin
      rd_idx = IDXW'(k); #1;
      if (k < m_count) begin
        chk(rd_hit == 1, "R6 rd_hit", rd_hit, 1);
        chk(rd_base == m_base[k], "R6 rd_base", rd_base, m_base[k]);
        chk(rd_size == m_size[k], "R6 rd_size", rd_size, m_size[k]);
        chk(rd_irq == m_irq[k], "R6 rd_irq", rd_irq, m_irq[k]);
        chk(rd_irq_cnt == m_cnt[k], "R6 rd_irq_cnt", rd_irq_cnt, m_cnt[k]);
      end else chk(rd_hit == 0, "R6 rd_hit empty slot", rd_hit, 0);
    end
    chk(tbl_count == CNTW'(m_count), "R6 tbl_count", tbl_count, m_count);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(tbl_count == 0, "R1 tbl_count", tbl_count, 0);
    chk(tbl_full == 0, "R1 tbl_full", tbl_full, 0);
    chk(irq_vec == 0, "R1 irq_vec", irq_vec, 0);
    chk(irq_err == 0, "R1 irq_err", irq_err, 0);
    chk(req_ready == 1, "R1 req_ready", req_ready, 1);
    @(posedge clk); #1;
    // R1 counters zero: allocation from reset hands out zero for irq
    reg_dev(32'h0000_5000, 32'h100, 0, 1);    // fixed base, irq alloc -> 0, fi=1
    // R2 init
    do_init(32'h1000_0000, 8'd5);
    chk(tbl_count == 1, "R2 table kept across init", tbl_count, 1);
    reg_dev(0, 32'h1000, 0, 2);               // R3 + R5 alloc
    reg_dev(32'h2000_0000, 32'h100, 0, 0);    // R4 kept, R5 no lines
    reg_dev(0, 32'h2000, 8'd20, 1);           // R3 alloc base, R5 fixed irq
    reg_dev(0, 32'h10, 0, 3);                 // R3, R5 alloc
    check_table();
    // R8 / R9 interrupts
    drive_irq(1, 1, 1, 0);                    // line 6
    drive_irq(4, 2, 1, 0);                    // line 9
    drive_irq(1, 2, 1, 1);                    // index == count
    drive_irq(2, 0, 1, 1);                    // device with no lines
    drive_irq(6, 0, 1, 1);                    // empty slot
    drive_irq(1, 1, 0, 0);                    // clear line 6
    reg_dev(32'h3000_0000, 32'h80, 8'd30, 4); // lines 30..33
    drive_irq(5, 1, 1, 0);                    // line 31
    drive_irq(5, 3, 1, 1);                    // line 33 >= NIRQ
    // fill and overflow (R7)
    reg_dev(0, 32'h40, 0, 1);
    reg_dev(0, 32'h40, 0, 1);
    @(negedge clk);
    chk(tbl_full == 1, "R7 tbl_full at depth", tbl_full, 1);
    @(posedge clk); #1;
    reg_dev(0, 32'h40, 0, 1);
    @(negedge clk);
    chk(tbl_count == CNTW'(DEPTH), "R7 count unchanged on reject", tbl_count, DEPTH);
    @(posedge clk); #1;
    check_table();
    chk(q_base.size() == 0, "R10 all responses seen", q_base.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule